// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a 32-bit processor that retires one instruction on every rising clock edge. In each cycle the program counter indexes a word-addressed instruction store. The fetched word is decoded and the register file is read through two combinational ports. An arithmetic unit then produces either a result, a memory address or an equality test. A data store can be read combinationally or written on the edge, and a single register write commits on the same edge as the next program counter.

The instruction mix is nine operations:

- register-register add, subtract, bitwise AND and signed set-less-than;
- OR with a zero-extended immediate;
- word load and word store;
- branch-if-equal;
- absolute jump within the current 256 MiB region.

Any other encoding retires as a no-op that only advances the program counter. Both stores are internal arrays that a test environment fills before releasing reset. The only outputs are taps that show the program counter and the register write about to commit.

Top module: `sc_core`

## Requirements
- R1: Reset is synchronous and active high. While it is held, the program counter is 0 and no register or data-store write takes place. The first instruction after release is fetched from address 0.
- R2: Every instruction that is neither a taken branch nor a jump retires in one cycle, and the next program counter is the current one plus 4.
- R3: Opcode 0 selects register-register operations, with fields rs = bits 25:21, rt = 20:16, rd = 15:11 and function = 5:0. The function codes are 0x20 for add, 0x22 for subtract and 0x24 for AND. The result wraps modulo 2^32 and is written to rd.
- R4: Function code 0x2A (set-less-than) writes 1 to rd when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R5: Opcode 0x0D ORs rs with the 16-bit immediate (bits 15:0) zero-extended and writes the result to rt.
- R6: Opcode 0x23 loads the word at byte address rs + sign-extended immediate into rt. Opcode 0x2B stores rt to that address and writes no register. The word index is the address with its two low bits dropped.
- R7: Opcode 0x04 branches when rs equals rt. The target is PC + 4 + (sign-extended immediate × 4), so negative offsets reach backward. When the operands differ, execution falls through to PC + 4.
- R8: Opcode 0x02 jumps to {bits 31:28 of PC + 4, instruction bits 25:0, 2'b00}.
- R9: Register 0 always reads as zero. A write aimed at it is dropped, and the write tap shows no write.
- R10: An unknown opcode, or opcode 0 with an unknown function code, writes nothing and advances the program counter by 4.
- R11: The write taps show, during a cycle, the register number and value that commit at the next rising edge. The enable tap is high only when such a write commits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state element updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Address of the instruction executing this cycle |
| dbg_wr_en | output | 1 | High when a register write commits at the next edge |
| dbg_wr_addr | output | 5 | Register number of that write |
| dbg_wr_data | output | 32 | Value of that write |

## Verification
One fixed program exercises every operation and is rerun for all 64 ordered pairs drawn from eight operand values: zero, one, all ones, the largest and smallest signed values, a small positive value, a mixed pattern and a half-ones pattern. The extreme pairs separate signed from unsigned comparison in set-less-than and expose wrap-around in add and subtract. The mixed patterns separate the zero-extended OR immediate from a sign-extended one. Equal pairs take the branch and unequal pairs fall through, so both outcomes are seen. Fixed steps check a negative load offset, a backward branch onto itself, a forward jump, a write aimed at register 0 and an unknown opcode, with the program counter compared on every cycle.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int unsigned XLEN = 32;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_JUMP  = 6'h02;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_is_rd;
    logic    src_imm;
    logic    imm_zext;
    logic    mem_we;
    logic    load_wb;
    logic    is_branch;
    logic    is_jump;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] widen_imm(input logic [15:0] imm, input logic zext);
    return zext ? {16'h0000, imm} : {{16{imm[15]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] seq_pc,
                                                  input logic [15:0]     offs);
    return seq_pc + {widen_imm(offs, 1'b0)[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] seq_pc,
                                                input logic [25:0]     field);
    return {seq_pc[XLEN-1:XLEN-4], field, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] y;
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
    return y;
  endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    case (opcode)
      OPC_RTYPE: begin
        ctrl.dst_is_rd = 1'b1;
        case (funct)
          FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_ADD; end
          FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SUB; end
          FN_AND: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_AND; end
          FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SLT; end
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OPC_ORI: begin
        ctrl.reg_we   = 1'b1;
        ctrl.src_imm  = 1'b1;
        ctrl.imm_zext = 1'b1;
        ctrl.alu_op   = ALU_OR;
      end
      OPC_LOAD: begin
        ctrl.reg_we  = 1'b1;
        ctrl.src_imm = 1'b1;
        ctrl.load_wb = 1'b1;
      end
      OPC_STORE: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_op    = ALU_SUB;
      end
      OPC_JUMP: ctrl.is_jump = 1'b1;
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            is_zero
);

  assign y       = alu_eval(op, a, b);
  assign is_zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned NREG  = 32,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  output logic [WIDTH-1:0] rdata_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_b
);

  // Register 0 has no storage; entry k holds register k+1.
  logic [WIDTH-1:0] store_q [NREG-1];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) store_q[waddr - 1'b1] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : store_q[raddr_a - 1'b1];
  assign rdata_b = (raddr_b == '0) ? '0 : store_q[raddr_b - 1'b1];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int unsigned IMEM_AW = 6,
  parameter int unsigned DMEM_AW = 6,
  parameter int unsigned NREG    = 32,
  localparam int unsigned IMEM_WORDS = 1 << IMEM_AW,
  localparam int unsigned DMEM_WORDS = 1 << DMEM_AW,
  localparam int unsigned RAW        = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [31:0]     dbg_pc,
  output logic            dbg_wr_en,
  output logic [RAW-1:0]  dbg_wr_addr,
  output logic [31:0]     dbg_wr_data
);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  initial begin
    for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
  end

  logic [XLEN-1:0] pc_q, pc_plus4, pc_next;
  logic [XLEN-1:0] instr;
  logic [5:0]      op_f, fn_f;
  logic [RAW-1:0]  rs_f, rt_f, rd_f;
  logic [15:0]     imm_f;
  logic [25:0]     jfield;
  ctrl_t           ctrl;
  logic [XLEN-1:0] rs_val, rt_val, imm_val, alu_b, alu_y, ld_val;
  logic            alu_zero;

  // Named events for the checker.
  logic            take_branch, take_jump, wb_en, dm_we;
  logic [RAW-1:0]  wb_addr;
  logic [XLEN-1:0] wb_data;

  assign instr  = imem[pc_q[IMEM_AW+1:2]];
  assign op_f   = instr[31:26];
  assign rs_f   = instr[21 +: RAW];
  assign rt_f   = instr[16 +: RAW];
  assign rd_f   = instr[11 +: RAW];
  assign fn_f   = instr[5:0];
  assign imm_f  = instr[15:0];
  assign jfield = instr[25:0];

  logic unused_bits;
  assign unused_bits = ^instr[10:6];

  sc_decode u_dec (
    .opcode (op_f),
    .funct  (fn_f),
    .ctrl   (ctrl)
  );

  assign wb_addr = ctrl.dst_is_rd ? rd_f : rt_f;
  assign wb_en   = ctrl.reg_we && !rst && (wb_addr != '0);
  assign dm_we   = ctrl.mem_we && !rst;

  sc_regfile #(.NREG(NREG), .WIDTH(XLEN)) u_rf (
    .clk     (clk),
    .we      (wb_en),
    .waddr   (wb_addr),
    .wdata   (wb_data),
    .raddr_a (rs_f),
    .rdata_a (rs_val),
    .raddr_b (rt_f),
    .rdata_b (rt_val)
  );

  assign imm_val = widen_imm(imm_f, ctrl.imm_zext);
  assign alu_b   = ctrl.src_imm ? imm_val : rt_val;

  sc_alu u_alu (
    .op      (ctrl.alu_op),
    .a       (rs_val),
    .b       (alu_b),
    .y       (alu_y),
    .is_zero (alu_zero)
  );

  assign ld_val = dmem[alu_y[DMEM_AW+1:2]];

  always_ff @(posedge clk) begin
    if (dm_we) dmem[alu_y[DMEM_AW+1:2]] <= rt_val;
  end

  assign wb_data = ctrl.load_wb ? ld_val : alu_y;

  assign pc_plus4    = pc_q + 32'd4;
  assign take_branch = ctrl.is_branch && alu_zero;
  assign take_jump   = ctrl.is_jump;

  always_comb begin
    if (take_jump)        pc_next = jump_dest(pc_plus4, jfield);
    else if (take_branch) pc_next = branch_dest(pc_plus4, imm_f);
    else                  pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign dbg_pc      = pc_q;
  assign dbg_wr_en   = wb_en;
  assign dbg_wr_addr = wb_addr;
  assign dbg_wr_data = wb_data;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
  parameter int unsigned RAW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic [31:0]    pc,
  input logic [31:0]    pc_seq,
  input logic           take_branch,
  input logic           take_jump,
  input logic           wb_en,
  input logic           dm_we,
  input logic [RAW-1:0] rf_raddr,
  input logic [31:0]    rf_rdata
);

  // R1: nothing is written while reset is held
  always_ff @(posedge clk) begin
    if (rst) assert_quiet_in_reset_R1: assert (!wb_en && !dm_we);
  end

  // R1: the program counter is 0 after a reset edge
  assert_pc_cleared_R1: assert property (@(posedge clk) rst |=> (pc == 32'd0));

  // R2: a sequential instruction advances by one word
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!take_branch && !take_jump) |=> (pc == $past(pc) + 32'd4));

  // R2: the program counter stays word aligned
  assert_pc_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  // R7: branch and jump are never both selected
  assert_ctl_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(take_branch && take_jump));

  // R8: a jump keeps the top four bits of the sequential address
  assert_jump_region_R8: assert property (@(posedge clk) disable iff (rst)
    take_jump |=> (pc[31:28] == $past(pc_seq[31:28])));

  // R9: register 0 reads as zero
  assert_zero_reg_R9: assert property (@(posedge clk) disable iff (rst)
    (rf_raddr == '0) |-> (rf_rdata == 32'd0));

endmodule

bind sc_core sc_core_chk #(.RAW(RAW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pc          (pc_q),
  .pc_seq      (pc_plus4),
  .take_branch (take_branch),
  .take_jump   (take_jump),
  .wb_en       (wb_en),
  .dm_we       (dm_we),
  .rf_raddr    (rs_f),
  .rf_rdata    (rs_val)
);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_pc;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_addr;
  logic [31:0] dbg_wr_data;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  sc_core uut (
    .clk         (clk),
    .rst         (rst),
    .dbg_pc      (dbg_pc),
    .dbg_wr_en   (dbg_wr_en),
    .dbg_wr_addr (dbg_wr_addr),
    .dbg_wr_data (dbg_wr_data)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  function automatic logic [31:0] operand(int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'h0000_0005;
      6: return 32'h1234_5678;
      default: return 32'hFFFF_0000;
    endcase
  endfunction

  task automatic step(input logic [31:0] epc, input logic een, input int eaddr,
                      input logic [31:0] edata, input string req);
    vectors++;
    if (dbg_pc !== epc) begin
      misses++;
      $display("FAIL %s pc: actual %h expected %h", req, dbg_pc, epc);
    end else if (dbg_wr_en !== een) begin
      misses++;
      $display("FAIL %s at pc %h wr_en: actual %b expected %b", req, epc, dbg_wr_en, een);
    end else if (een && (dbg_wr_addr !== eaddr[4:0] || dbg_wr_data !== edata)) begin
      misses++;
      $display("FAIL %s at pc %h write: actual r%0d=%h expected r%0d=%h",
               req, epc, dbg_wr_addr, dbg_wr_data, eaddr, edata);
    end
    @(negedge clk); #1;
  endtask

  task automatic load_program();
    uut.imem[0]  = enc_i(6'h23, 0, 1, 16'd0);      // lw r1,0(r0)
    uut.imem[1]  = enc_i(6'h23, 0, 2, 16'd4);      // lw r2,4(r0)
    uut.imem[2]  = enc_r(1, 2, 3, 6'h20);          // add
    uut.imem[3]  = enc_r(1, 2, 4, 6'h22);          // sub
    uut.imem[4]  = enc_r(1, 2, 5, 6'h24);          // and
    uut.imem[5]  = enc_r(1, 2, 6, 6'h2A);          // slt
    uut.imem[6]  = enc_i(6'h0D, 1, 7, 16'h8421);   // ori
    uut.imem[7]  = enc_i(6'h2B, 0, 3, 16'd8);      // sw r3,8(r0)
    uut.imem[8]  = enc_i(6'h0D, 0, 15, 16'd12);    // ori r15,r0,12
    uut.imem[9]  = enc_i(6'h23, 15, 8, 16'hFFFC);  // lw r8,-4(r15)
    uut.imem[10] = enc_i(6'h04, 1, 2, 16'd1);      // beq r1,r2,+1
    uut.imem[11] = enc_i(6'h0D, 0, 9, 16'd1);
    uut.imem[12] = enc_i(6'h0D, 0, 10, 16'd2);
    uut.imem[13] = {6'h02, 26'd15};                // j word 15
    uut.imem[14] = enc_i(6'h0D, 0, 11, 16'd3);     // skipped
    uut.imem[15] = enc_r(1, 1, 0, 6'h20);          // add r0 (dropped)
    uut.imem[16] = enc_r(0, 0, 12, 6'h20);         // add r12,r0,r0
    uut.imem[17] = 32'hFC00_0000;                  // unknown opcode
    uut.imem[18] = enc_r(1, 2, 14, 6'h27);         // unknown function
    uut.imem[19] = enc_i(6'h0D, 0, 13, 16'd7);
    uut.imem[20] = enc_i(6'h04, 0, 0, 16'hFFFF);   // beq r0,r0,-1
  endtask

  task automatic run_case(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] lt;
    lt = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    rst = 1'b1;
    load_program();
    uut.dmem[0] = a;
    uut.dmem[1] = b;
    uut.dmem[2] = 32'hDEAD_BEEF;
    @(negedge clk); @(negedge clk); #1;
    vectors++;
    if (dbg_pc !== 32'd0 || dbg_wr_en !== 1'b0) begin
      misses++;
      $display("FAIL R1 in reset: actual pc %h en %b expected pc 0 en 0", dbg_pc, dbg_wr_en);
    end
    rst = 1'b0; #1;
    step(32'd0,  1, 1, a,              "R6");
    step(32'd4,  1, 2, b,              "R6");
    step(32'd8,  1, 3, a + b,          "R3");
    step(32'd12, 1, 4, a - b,          "R3");
    step(32'd16, 1, 5, a & b,          "R3");
    step(32'd20, 1, 6, lt,             "R4");
    step(32'd24, 1, 7, a | 32'h8421,   "R5");
    step(32'd28, 0, 0, 0,              "R6");
    step(32'd32, 1, 15, 32'd12,        "R2");
    step(32'd36, 1, 8, a + b,          "R6");
    step(32'd40, 0, 0, 0,              "R7");
    if (a != b) step(32'd44, 1, 9, 32'd1, "R7");
    step(32'd48, 1, 10, 32'd2,         "R7");
    step(32'd52, 0, 0, 0,              "R8");
    step(32'd60, 0, 0, 0,              "R9");
    step(32'd64, 1, 12, 32'd0,         "R9");
    step(32'd68, 0, 0, 0,              "R10");
    step(32'd72, 0, 0, 0,              "R10");
    step(32'd76, 1, 13, 32'd7,         "R11");
    step(32'd80, 0, 0, 0,              "R7");
    step(32'd80, 0, 0, 0,              "R7");
  endtask

  initial begin
    @(negedge clk); #1;
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        run_case(operand(i), operand(j));
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule